// File: doc/BRIEF.md
# Mesh Vertex Fetch Sequencer

This block walks a rectangular grid of texture-coordinate vertices held in memory and turns every grid cell into one quad record for a downstream rasterizer. Software sets a vertex-array base address, the last horizontal and last vertical mesh index, a destination offset pair and a destination cell size, then pulses `start`. The sequencer reads vertex records over a request/response channel, each side with a valid/ready handshake, and puts together the four corners of each cell. It then presents a quad that carries the destination rectangle and the four texture coordinate pairs.

The vertex array always has a row pitch of 128 entries, whatever size the active mesh has. Each record is 8 bytes long: a 32-bit U followed by a 32-bit V, both stored most significant byte first. Texture coordinates pass through unchanged in a fixed-point format with 6 fractional bits. Within a row, the sequencer keeps the right-hand column of one cell and uses it as the left-hand column of the next, so each vertex is read only once per row. After the last quad is taken, a one-cycle `done` pulse ends the job.

Top module: `mesh_seq`

## Requirements
- R1: After reset, `busy`, `done`, `reqValid` and `quadValid` are all low.
- R2: The vertex at column c, row r is read at `reqAddr = baseAddr + 8*(128*r + c)`, modulo 2^ADDR_W.
- R3: In each cell row y, the reads run column by column from c = 0 to c = hLast. Within a column the row-y vertex comes first and the row-y+1 vertex second. Each row therefore takes exactly 2*(hLast+1) reads.
- R4: `rspData` carries the record in memory byte order, with byte `addr+k` in bits [8k+7:8k]. U comes from bytes 0..3 and V from bytes 4..7, each read most significant byte first.
- R5: Cells are emitted row by row, with y as the outer index and x as the inner index, for hLast*vLast quads in total.
- R6: In `quadU`/`quadV`, slot k occupies bits [32k+31:32k]. Slot 0 holds corner (x,y), slot 1 holds (x+1,y), slot 2 holds (x+1,y+1) and slot 3 holds (x,y+1).
- R7: `quadX0 = offH + x*sqW` and `quadX1 = quadX0 + sqW`. `quadY0 = offV + y*sqH` and `quadY1 = quadY0 + sqH`. All four are computed modulo 2^COORD_W.
- R8: While a request or a quad is stalled (valid high, ready low), it stays valid and keeps its contents unchanged. At most one read is outstanding at any time.
- R9: `done` is high for exactly one cycle: the cycle that follows the acceptance of the final quad. In that cycle `busy` is low.
- R10: If `hLast` or `vLast` is zero at start, `done` is high in the cycle after start, and no read and no quad is issued.
- R11: All job inputs are captured when a start is accepted. While `busy` is high, `start` and changes on the job inputs have no effect on the running job.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a job (ignored while busy) |
| baseAddr | input | ADDR_W | Byte address of vertex (0,0) |
| hLast | input | IDX_W | Last horizontal mesh index (cell count per row) |
| vLast | input | IDX_W | Last vertical mesh index (cell row count) |
| offH | input | COORD_W | Destination horizontal offset |
| offV | input | COORD_W | Destination vertical offset |
| sqW | input | COORD_W | Destination cell width |
| sqH | input | COORD_W | Destination cell height |
| busy | output | 1 | Job in progress |
| done | output | 1 | One-cycle end-of-job pulse |
| reqValid | output | 1 | Read request valid |
| reqReady | input | 1 | Read request accepted |
| reqAddr | output | ADDR_W | Byte address of the vertex record |
| rspValid | input | 1 | Read data valid |
| rspReady | output | 1 | Sequencer can take read data |
| rspData | input | 64 | Vertex record in memory byte order |
| quadValid | output | 1 | Quad record valid |
| quadReady | input | 1 | Quad record accepted |
| quadX0 | output | COORD_W | Left destination edge |
| quadY0 | output | COORD_W | Top destination edge |
| quadX1 | output | COORD_W | Right destination edge |
| quadY1 | output | COORD_W | Bottom destination edge |
| quadU | output | 128 | Four U coordinates, slot k in bits [32k+31:32k] |
| quadV | output | 128 | Four V coordinates, slot k in bits [32k+31:32k] |

## Verification
The bench builds the block with its default parameters: 32-bit addresses, 7-bit mesh indices with a 128-entry pitch, and 16-bit destination coordinates. With these settings a single row of 127 cells reaches the widest column index the pitch allows. A two-row mesh crosses the row boundary at index 128. Negative offsets make the coordinate sums wrap. The memory model returns distinct bytes in every lane, so any swap of byte order, corner slots or column reuse shows up in the quad contents. Stalls on the request, the response latency and the quad handshake exercise the hold rules.

// File: rtl/mesh_seq_pkg.sv
package mesh_seq_pkg;

  localparam int TEX_W      = 32;
  localparam int VTX_BITS   = 2 * TEX_W;
  localparam int VTX_SHIFT  = 3;
  localparam int CORNERS    = 4;

  typedef struct packed {
    logic [TEX_W-1:0] u;
    logic [TEX_W-1:0] v;
  } texPair_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_REQ,
    ST_RSP,
    ST_EMIT
  } seqState_t;

  // strobes from the control into the datapath
  typedef struct packed {
    logic latchJob;
    logic storeVert;
    logic vertBottom;
    logic vertLeft;
    logic stepCell;
    logic stepRow;
  } seqStrobe_t;

  function automatic logic [TEX_W-1:0] fromBigEndian(input logic [TEX_W-1:0] lanes);
    logic [TEX_W-1:0] w;
    for (int b = 0; b < TEX_W / 8; b++) begin
      w[TEX_W-1-8*b -: 8] = lanes[8*b +: 8];
    end
    return w;
  endfunction

endpackage

// File: rtl/mesh_seq_ctrl.sv
module mesh_seq_ctrl
  import mesh_seq_pkg::*;
#(
  parameter int IDX_W = 7
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [IDX_W-1:0] hLast,
  input  logic [IDX_W-1:0] vLast,
  input  logic             reqReady,
  input  logic             rspValid,
  input  logic             quadReady,
  output logic             reqValid,
  output logic             rspReady,
  output logic             quadValid,
  output logic             busy,
  output logic             done,
  output logic [IDX_W-1:0] fetchCol,
  output logic [IDX_W-1:0] fetchRow,
  output seqStrobe_t       strobe
);

  seqState_t        state;
  logic [IDX_W-1:0] col;
  logic [IDX_W-1:0] rowY;
  logic             bottom;
  logic [IDX_W-1:0] hLastQ;
  logic [IDX_W-1:0] vLastQ;
  logic             doneQ;
  logic             rowEnd;
  logic             lastRow;
  logic             zeroJob;

  assign rowEnd  = (col == hLastQ);
  assign lastRow = (({1'b0, rowY} + (IDX_W+1)'(1)) == {1'b0, vLastQ});
  assign zeroJob = (hLast == '0) || (vLast == '0);

  assign reqValid  = (state == ST_REQ);
  assign rspReady  = (state == ST_RSP);
  assign quadValid = (state == ST_EMIT);
  assign busy      = (state != ST_IDLE);
  assign done      = doneQ;
  assign fetchCol  = col;
  assign fetchRow  = rowY + IDX_W'(bottom);

  always_comb begin
    strobe            = '0;
    strobe.latchJob   = (state == ST_IDLE) && start;
    strobe.storeVert  = (state == ST_RSP) && rspValid;
    strobe.vertBottom = bottom;
    strobe.vertLeft   = (col == '0);
    strobe.stepCell   = (state == ST_EMIT) && quadReady && !rowEnd;
    strobe.stepRow    = (state == ST_EMIT) && quadReady && rowEnd;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      col    <= '0;
      rowY   <= '0;
      bottom <= 1'b0;
      hLastQ <= '0;
      vLastQ <= '0;
      doneQ  <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            hLastQ <= hLast;
            vLastQ <= vLast;
            col    <= '0;
            rowY   <= '0;
            bottom <= 1'b0;
            if (zeroJob) doneQ <= 1'b1;
            else         state <= ST_REQ;
          end
        end
        ST_REQ: begin
          if (reqReady) state <= ST_RSP;
        end
        ST_RSP: begin
          if (rspValid) begin
            if (!bottom) begin
              bottom <= 1'b1;
              state  <= ST_REQ;
            end else begin
              bottom <= 1'b0;
              if (col == '0) begin
                col   <= IDX_W'(1);
                state <= ST_REQ;
              end else begin
                state <= ST_EMIT;
              end
            end
          end
        end
        ST_EMIT: begin
          if (quadReady) begin
            if (!rowEnd) begin
              col   <= col + IDX_W'(1);
              state <= ST_REQ;
            end else if (lastRow) begin
              state <= ST_IDLE;
              doneQ <= 1'b1;
            end else begin
              rowY  <= rowY + IDX_W'(1);
              col   <= '0;
              state <= ST_REQ;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/mesh_seq_dpath.sv
module mesh_seq_dpath
  import mesh_seq_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int IDX_W      = 7,
  parameter int PITCH_LOG2 = 7,
  parameter int COORD_W    = 16
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  seqStrobe_t                 strobe,
  input  logic [IDX_W-1:0]           fetchCol,
  input  logic [IDX_W-1:0]           fetchRow,
  input  logic [ADDR_W-1:0]          baseAddr,
  input  logic [COORD_W-1:0]         offH,
  input  logic [COORD_W-1:0]         offV,
  input  logic [COORD_W-1:0]         sqW,
  input  logic [COORD_W-1:0]         sqH,
  input  logic [VTX_BITS-1:0]        rspData,
  output logic [ADDR_W-1:0]          reqAddr,
  output logic [COORD_W-1:0]         quadX0,
  output logic [COORD_W-1:0]         quadY0,
  output logic [COORD_W-1:0]         quadX1,
  output logic [COORD_W-1:0]         quadY1,
  output logic [CORNERS*TEX_W-1:0]   quadU,
  output logic [CORNERS*TEX_W-1:0]   quadV
);

  localparam int ROWS = 2;

  logic [ADDR_W-1:0]  baseQ;
  logic [COORD_W-1:0] offHQ;
  logic [COORD_W-1:0] sqWQ;
  logic [COORD_W-1:0] sqHQ;
  logic [COORD_W-1:0] dstLeft;
  logic [COORD_W-1:0] dstTop;
  logic [ADDR_W-1:0]  vtxIndex;
  texPair_t           inVert;
  texPair_t           colL [ROWS];
  texPair_t           colR [ROWS];
  texPair_t           corner [CORNERS];

  assign vtxIndex = (ADDR_W'(fetchRow) << PITCH_LOG2) + ADDR_W'(fetchCol);
  assign reqAddr  = baseQ + (vtxIndex << VTX_SHIFT);

  assign inVert.u = fromBigEndian(rspData[TEX_W-1:0]);
  assign inVert.v = fromBigEndian(rspData[VTX_BITS-1:TEX_W]);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseQ   <= '0;
      offHQ   <= '0;
      sqWQ    <= '0;
      sqHQ    <= '0;
      dstLeft <= '0;
      dstTop  <= '0;
    end else begin
      if (strobe.latchJob) begin
        baseQ   <= baseAddr;
        offHQ   <= offH;
        sqWQ    <= sqW;
        sqHQ    <= sqH;
        dstLeft <= offH;
        dstTop  <= offV;
      end
      if (strobe.stepCell) dstLeft <= dstLeft + sqWQ;
      if (strobe.stepRow) begin
        dstLeft <= offHQ;
        dstTop  <= dstTop + sqHQ;
      end
    end
  end

  // one left/right register pair per cell row edge (top, bottom)
  for (genvar r = 0; r < ROWS; r++) begin : g_edge
    always_ff @(posedge clk) begin
      if (!rstN) begin
        colL[r] <= '0;
        colR[r] <= '0;
      end else begin
        if (strobe.storeVert && (strobe.vertBottom == 1'(r))) begin
          if (strobe.vertLeft) colL[r] <= inVert;
          else                 colR[r] <= inVert;
        end else if (strobe.stepCell) begin
          colL[r] <= colR[r];
        end
      end
    end
  end

  // clockwise corner order starting at the top-left vertex
  assign corner[0] = colL[0];
  assign corner[1] = colR[0];
  assign corner[2] = colR[1];
  assign corner[3] = colL[1];

  for (genvar k = 0; k < CORNERS; k++) begin : g_slot
    assign quadU[k*TEX_W +: TEX_W] = corner[k].u;
    assign quadV[k*TEX_W +: TEX_W] = corner[k].v;
  end

  assign quadX0 = dstLeft;
  assign quadX1 = dstLeft + sqWQ;
  assign quadY0 = dstTop;
  assign quadY1 = dstTop + sqHQ;

endmodule

// File: rtl/mesh_seq.sv
module mesh_seq
  import mesh_seq_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int IDX_W      = 7,
  parameter int PITCH_LOG2 = 7,
  parameter int COORD_W    = 16
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     start,
  input  logic [ADDR_W-1:0]        baseAddr,
  input  logic [IDX_W-1:0]         hLast,
  input  logic [IDX_W-1:0]         vLast,
  input  logic [COORD_W-1:0]       offH,
  input  logic [COORD_W-1:0]       offV,
  input  logic [COORD_W-1:0]       sqW,
  input  logic [COORD_W-1:0]       sqH,
  output logic                     busy,
  output logic                     done,
  output logic                     reqValid,
  input  logic                     reqReady,
  output logic [ADDR_W-1:0]        reqAddr,
  input  logic                     rspValid,
  output logic                     rspReady,
  input  logic [63:0]              rspData,
  output logic                     quadValid,
  input  logic                     quadReady,
  output logic [COORD_W-1:0]       quadX0,
  output logic [COORD_W-1:0]       quadY0,
  output logic [COORD_W-1:0]       quadX1,
  output logic [COORD_W-1:0]       quadY1,
  output logic [127:0]             quadU,
  output logic [127:0]             quadV
);

  seqStrobe_t       strobe;
  logic [IDX_W-1:0] fetchCol;
  logic [IDX_W-1:0] fetchRow;

  mesh_seq_ctrl #(.IDX_W(IDX_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .hLast     (hLast),
    .vLast     (vLast),
    .reqReady  (reqReady),
    .rspValid  (rspValid),
    .quadReady (quadReady),
    .reqValid  (reqValid),
    .rspReady  (rspReady),
    .quadValid (quadValid),
    .busy      (busy),
    .done      (done),
    .fetchCol  (fetchCol),
    .fetchRow  (fetchRow),
    .strobe    (strobe)
  );

  mesh_seq_dpath #(
    .ADDR_W     (ADDR_W),
    .IDX_W      (IDX_W),
    .PITCH_LOG2 (PITCH_LOG2),
    .COORD_W    (COORD_W)
  ) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .fetchCol (fetchCol),
    .fetchRow (fetchRow),
    .baseAddr (baseAddr),
    .offH     (offH),
    .offV     (offV),
    .sqW      (sqW),
    .sqH      (sqH),
    .rspData  (rspData),
    .reqAddr  (reqAddr),
    .quadX0   (quadX0),
    .quadY0   (quadY0),
    .quadX1   (quadX1),
    .quadY1   (quadY1),
    .quadU    (quadU),
    .quadV    (quadV)
  );

endmodule

// File: rtl/mesh_seq_checker.sv
module mesh_seq_checker #(
  parameter int ADDR_W  = 32,
  parameter int IDX_W   = 7,
  parameter int COORD_W = 16
) (
  input logic               clk,
  input logic               rstN,
  input logic               start,
  input logic [IDX_W-1:0]   hLast,
  input logic [IDX_W-1:0]   vLast,
  input logic               busy,
  input logic               done,
  input logic               reqValid,
  input logic               reqReady,
  input logic [ADDR_W-1:0]  reqAddr,
  input logic               rspValid,
  input logic               rspReady,
  input logic               quadValid,
  input logic               quadReady,
  input logic [COORD_W-1:0] quadX0,
  input logic [COORD_W-1:0] quadY0,
  input logic [COORD_W-1:0] quadX1,
  input logic [COORD_W-1:0] quadY1,
  input logic [127:0]       quadU,
  input logic [127:0]       quadV
);

  logic [1:0] inFlight;

  always_ff @(posedge clk) begin
    if (!rstN) inFlight <= '0;
    else inFlight <= inFlight + 2'(reqValid && reqReady) - 2'(rspValid && rspReady);
  end

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!reqValid && !quadValid));

  assert_req_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqReady) |=> (reqValid && $stable(reqAddr)));

  assert_quad_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (quadValid && !quadReady) |=> (quadValid && $stable(quadX0) && $stable(quadY0)
      && $stable(quadX1) && $stable(quadY1) && $stable(quadU) && $stable(quadV)));

  assert_single_read_R8: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> (inFlight == 2'd0));

  assert_rsp_expected_R8: assert property (@(posedge clk) disable iff (!rstN)
    rspReady |-> (inFlight == 2'd1));

  assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy && !quadValid && !reqValid));

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_zero_job_R10: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy && ((hLast == '0) || (vLast == '0))) |=> (done && !busy && !reqValid));

endmodule

bind mesh_seq mesh_seq_checker #(
  .ADDR_W  (ADDR_W),
  .IDX_W   (IDX_W),
  .COORD_W (COORD_W)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .start     (start),
  .hLast     (hLast),
  .vLast     (vLast),
  .busy      (busy),
  .done      (done),
  .reqValid  (reqValid),
  .reqReady  (reqReady),
  .reqAddr   (reqAddr),
  .rspValid  (rspValid),
  .rspReady  (rspReady),
  .quadValid (quadValid),
  .quadReady (quadReady),
  .quadX0    (quadX0),
  .quadY0    (quadY0),
  .quadX1    (quadX1),
  .quadY1    (quadY1),
  .quadU     (quadU),
  .quadV     (quadV)
);

// File: tb/mesh_seq_bench.sv
module mesh_seq_bench;

  localparam int ADDR_W  = 32;
  localparam int IDX_W   = 7;
  localparam int COORD_W = 16;
  localparam int LOG_N   = 512;

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic               start = 1'b0;
  logic [ADDR_W-1:0]  baseAddr = '0;
  logic [IDX_W-1:0]   hLast = '0;
  logic [IDX_W-1:0]   vLast = '0;
  logic [COORD_W-1:0] offH = '0, offV = '0, sqW = '0, sqH = '0;
  logic               busy, done, reqValid, rspReady, quadValid;
  logic               reqReady = 1'b0, rspValid = 1'b0, quadReady = 1'b0;
  logic [ADDR_W-1:0]  reqAddr;
  logic [63:0]        rspData = '0;
  logic [COORD_W-1:0] quadX0, quadY0, quadX1, quadY1;
  logic [127:0]       quadU, quadV;

  always #4 clk = ~clk;

  mesh_seq u_mesh_seq (
    .clk(clk), .rstN(rstN), .start(start), .baseAddr(baseAddr),
    .hLast(hLast), .vLast(vLast), .offH(offH), .offV(offV), .sqW(sqW), .sqH(sqH),
    .busy(busy), .done(done), .reqValid(reqValid), .reqReady(reqReady),
    .reqAddr(reqAddr), .rspValid(rspValid), .rspReady(rspReady), .rspData(rspData),
    .quadValid(quadValid), .quadReady(quadReady), .quadX0(quadX0), .quadY0(quadY0),
    .quadX1(quadX1), .quadY1(quadY1), .quadU(quadU), .quadV(quadV)
  );

  int nTests = 0;
  int nFail  = 0;
  int cyc    = 0;

  logic [ADDR_W-1:0]  reqLog [LOG_N];
  logic [COORD_W-1:0] qX0 [LOG_N], qY0 [LOG_N], qX1 [LOG_N], qY1 [LOG_N];
  logic [127:0]       qU [LOG_N], qV [LOG_N];
  int nReq, nQuad, doneCount, lastFireCyc, doneCyc, startCyc;
  bit reqStallMode, quadStallMode;
  int rspLat;
  logic [ADDR_W-1:0] memBase;
  bit pend, reqFire, rspFire;
  logic [ADDR_W-1:0] pendAddr;
  int waitCnt;

  function automatic logic [31:0] memU(input int idx);
    return {8'hA5, 8'(idx), 16'(idx * 64 + 3)};
  endfunction

  function automatic logic [31:0] memV(input int idx);
    return {16'(idx * 3 + 1), 8'h5A, 8'(idx >> 8)};
  endfunction

  function automatic logic [31:0] toLanes(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // memory model and quad sink, all decisions taken between clock edges
  always @(negedge clk) begin
    int idx;
    cyc++;
    if (!rstN) begin
      reqReady = 1'b0; rspValid = 1'b0; quadReady = 1'b0;
      pend = 0; reqFire = 0; rspFire = 0;
    end else begin
      if (rspFire) rspValid = 1'b0;
      if (reqFire) begin pend = 1; waitCnt = rspLat; end
      if (pend && !rspValid) begin
        if (waitCnt == 0) begin
          idx = int'((pendAddr - memBase) >> 3);
          rspData = {toLanes(memV(idx)), toLanes(memU(idx))};
          rspValid = 1'b1;
          pend = 0;
        end else waitCnt--;
      end
      reqReady = reqStallMode ? cyc[0] : 1'b1;
      reqFire = reqValid && reqReady;
      if (reqFire) begin
        pendAddr = reqAddr;
        if (nReq < LOG_N) reqLog[nReq] = reqAddr;
        nReq++;
      end
      rspFire = rspValid && rspReady;
      quadReady = quadStallMode ? ((cyc % 3) != 0) : 1'b1;
      if (quadValid && quadReady) begin
        if (nQuad < LOG_N) begin
          qX0[nQuad] = quadX0; qY0[nQuad] = quadY0;
          qX1[nQuad] = quadX1; qY1[nQuad] = quadY1;
          qU[nQuad] = quadU;   qV[nQuad] = quadV;
        end
        nQuad++;
        lastFireCyc = cyc;
      end
      if (done) begin doneCount++; doneCyc = cyc; end
    end
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  task automatic clearLogs();
    nReq = 0; nQuad = 0; doneCount = 0; lastFireCyc = -10; doneCyc = -10;
  endtask

  task automatic pulseStart();
    @(negedge clk); #1;
    start = 1'b1; startCyc = cyc;
    @(negedge clk); #1;
    start = 1'b0;
  endtask

  task automatic runJob(input string name, input logic [31:0] b, input int h, input int v,
                        input logic [15:0] oh, input logic [15:0] ov,
                        input logic [15:0] sw, input logic [15:0] sh,
                        input bit rs, input int lat, input bit qs, input bit disturb);
    int expReq, expQuad, badAddr, badUV, badXY, firstBad;
    logic [31:0] ea;
    logic [127:0] eu, ev;
    logic [15:0] ex0, ey0;
    int ci [4];
    clearLogs();
    reqStallMode = rs; rspLat = lat; quadStallMode = qs; memBase = b;
    baseAddr = b; hLast = IDX_W'(h); vLast = IDX_W'(v);
    offH = oh; offV = ov; sqW = sw; sqH = sh;
    pulseStart();
    if (disturb) begin
      // R11: new start and new job inputs while busy must not matter
      repeat (4) @(negedge clk); #1;
      baseAddr = 32'h7777_0000; hLast = 1; vLast = 1;
      offH = 16'h1234; offV = 16'h4321; sqW = 16'd99; sqH = 16'd77;
      start = 1'b1;
      @(negedge clk); #1;
      start = 1'b0;
    end
    for (int t = 0; t < 20000 && doneCount == 0; t++) @(negedge clk);
    repeat (5) @(negedge clk); #1;

    expReq = v * (h + 1) * 2;
    expQuad = h * v;
    check(nReq == expReq, "R3", {name, " read count"}, 128'(nReq), 128'(expReq));
    check(nQuad == expQuad, "R5", {name, " quad count"}, 128'(nQuad), 128'(expQuad));

    badAddr = 0; firstBad = -1;
    for (int y = 0; y < v; y++)
      for (int c = 0; c <= h; c++)
        for (int r = 0; r < 2; r++) begin
          int n = (y * (h + 1) + c) * 2 + r;
          ea = b + 32'(((y + r) * 128 + c) * 8);
          if (n < nReq && n < LOG_N && reqLog[n] !== ea) begin
            badAddr++;
            if (firstBad < 0) firstBad = n;
          end
        end
    if (firstBad >= 0)
      check(0, "R2", {name, " read address"}, 128'(reqLog[firstBad]), 128'(firstBad));
    else
      check(1, "R2", {name, " read address order"}, 0, 0);

    badUV = 0; badXY = 0;
    for (int y = 0; y < v; y++)
      for (int x = 0; x < h; x++) begin
        int n = y * h + x;
        ci[0] = y * 128 + x;       ci[1] = y * 128 + x + 1;
        ci[2] = (y + 1) * 128 + x + 1; ci[3] = (y + 1) * 128 + x;
        for (int k = 0; k < 4; k++) begin
          eu[k*32 +: 32] = memU(ci[k]);
          ev[k*32 +: 32] = memV(ci[k]);
        end
        ex0 = oh + 16'(x) * sw;
        ey0 = ov + 16'(y) * sh;
        if (n < nQuad && n < LOG_N) begin
          if (qU[n] !== eu || qV[n] !== ev) begin
            if (badUV == 0) check(0, "R6", {name, " corner U"}, qU[n], eu);
            badUV++;
          end
          if (qX0[n] !== ex0 || qX1[n] !== 16'(ex0 + sw) ||
              qY0[n] !== ey0 || qY1[n] !== 16'(ey0 + sh)) begin
            if (badXY == 0)
              check(0, "R7", {name, " dest rect"},
                    {qX0[n], qY0[n], qX1[n], qY1[n]},
                    {ex0, ey0, 16'(ex0 + sw), 16'(ey0 + sh)});
            badXY++;
          end
        end
      end
    if (badUV == 0) check(1, "R4", {name, " texture coords and byte order"}, 0, 0);
    if (badXY == 0) check(1, "R7", {name, " dest rect"}, 0, 0);
    check(doneCount == 1, "R9", {name, " done pulses"}, 128'(doneCount), 1);
    check(doneCyc == lastFireCyc + 1, "R9", {name, " done timing"},
          128'(doneCyc - lastFireCyc), 1);
    check(!busy, "R9", {name, " idle after done"}, 128'(busy), 0);
  endtask

  task automatic testReset();
    // R1
    check(!busy && !done && !reqValid && !quadValid, "R1", "reset outputs",
          {busy, done, reqValid, quadValid}, 0);
  endtask

  task automatic testZero(input string name, input int h, input int v);
    clearLogs();
    reqStallMode = 0; rspLat = 0; quadStallMode = 0; memBase = 0;
    baseAddr = 32'h100; hLast = IDX_W'(h); vLast = IDX_W'(v);
    pulseStart();
    repeat (10) @(negedge clk); #1;
    // R10
    check(doneCount == 1 && doneCyc == startCyc + 1, "R10", {name, " done timing"},
          128'(doneCyc - startCyc), 1);
    check(nReq == 0 && nQuad == 0, "R10", {name, " no traffic"},
          128'(nReq + nQuad), 0);
  endtask

  initial begin
    clearLogs();
    repeat (4) @(negedge clk); #1;
    rstN = 1'b1;
    @(negedge clk); #1;
    testReset();
    runJob("basic2x2", 32'h0001_0000, 2, 2, 16'd0, 16'd0, 16'd8, 16'd8, 0, 0, 0, 0);
    runJob("stall3x1", 32'h0020_0008, 3, 1, 16'hFFF0, 16'hFFFB, 16'd7, 16'd5, 1, 3, 1, 0);
    runJob("tall1x3", 32'hFFFF_F000, 1, 3, 16'hFFFF, 16'd10, 16'd300, 16'hFFFE, 0, 1, 1, 0);
    runJob("wide127", 32'h0040_0000, 127, 1, 16'd2, 16'd3, 16'd600, 16'd4, 0, 0, 0, 0);
    runJob("busyR11", 32'h0000_2000, 3, 2, 16'd5, 16'd6, 16'd16, 16'd12, 1, 2, 0, 1);
    testZero("zeroH", 0, 3);
    testZero("zeroV", 5, 0);
    runJob("afterZero", 32'h0003_0000, 2, 1, 16'd1, 16'd1, 16'd2, 16'd2, 0, 0, 1, 0);
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule